// File: doc/BRIEF.md
# Firmware Hub Single-Byte Write Initiator

This block is the host side of a nibble-wide multiplexed firmware-memory bus. It takes one write request at a time: a 4-bit device select, a 28-bit memory address and a data byte. It turns each request into a fixed 17-cycle frame on the bus. The frame starts with one cycle of active-low frame strobe together with the start code. The select, address, size and data nibbles follow. After that the initiator hands the bus to the target, samples the target's sync nibble, waits out the target's turnaround and takes the bus back.

The bus appears as three separate ports: a drive value, a drive enable and a sampled input, which the chip's pad ring combines into the bidirectional wires. When the bus is idle the initiator drives all ones. In the last frame cycle a one-cycle completion pulse reports the result, with an error flag if the sync nibble was anything other than 0000.

Top module: `fwh_wr_init`

## Requirements
- R1: After reset and whenever no frame is in progress, `req_ready` is 1, `frame_n` is 1, `bus_oe` is 1 with `bus_out` = 4'b1111, and `done` and `err` are 0.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1, and frame cycle 1 follows on the next cycle. `req_ready` stays 0 through all 17 frame cycles, so a request held valid during a frame starts no new frame.
- R3: In frame cycle 1 `frame_n` is 0 and the bus carries 4'b1110. `frame_n` is 1 in every other cycle.
- R4: Frame cycle 2 carries `req_id`.
- R5: Frame cycles 3 to 9 carry the address as seven nibbles, with bits 27:24 first and bits 3:0 last.
- R6: Frame cycle 10 carries the size nibble 4'b0000.
- R7: Frame cycle 11 carries data bits 3:0 and frame cycle 12 carries data bits 7:4.
- R8: In frame cycle 13 the initiator drives 4'b1111. In cycles 14, 15 and 16 `bus_oe` is 0.
- R9: `bus_in` is sampled at the end of frame cycle 15. A value of 4'b0000 completes the write with `err` = 0.
- R10: Any sampled sync value other than 4'b0000 sets `err` = 1 in the completion cycle, and the frame still runs its full 17 cycles.
- R11: In frame cycle 17 the initiator drives 4'b1111 again and `done` is 1 for exactly that cycle. The following cycle is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Initiator idle and able to accept |
| req_id | input | 4 | Device select of the target |
| req_addr | input | 28 | Byte address |
| req_data | input | 8 | Byte to write |
| bus_out | output | 4 | Nibble driven onto the bus |
| bus_oe | output | 1 | Drive enable for `bus_out` |
| bus_in | input | 4 | Nibble sampled from the bus |
| frame_n | output | 1 | Frame strobe, active low |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sync error, valid with `done` |

## Verification
On every cycle the assertions check that the strobe only falls right after an accepted request and then carries the start code. They also check that the completion pulse lasts one cycle and is followed by idle, that the error flag never appears without the pulse, and that the initiator never reports ready while the bus is released. The content of each frame cannot be checked this way: the select nibble, the address order, the data nibble order, the exact release window and how the sync value decides the error flag all need the bench's scenarios. There a scoreboard compares all 17 cycles against the request that caused them, with target sync values of zero and non-zero and with a request held back while a frame runs.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

    // Frame segments in bus order
    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_START = 4'd1,
        PH_SEL   = 4'd2,
        PH_ADDR  = 4'd3,
        PH_SIZE  = 4'd4,
        PH_DATA  = 4'd5,
        PH_HOFF  = 4'd6,   // host drives ones, then lets go
        PH_FLOAT = 4'd7,   // target takes over
        PH_SYNC  = 4'd8,   // target drives sync
        PH_TOFF  = 4'd9,   // target drives ones, then lets go
        PH_BACK  = 4'd10   // host takes bus back
    } phase_e;

    localparam logic [3:0] START_CODE = 4'b1110;
    localparam logic [3:0] SIZE_ONE   = 4'b0000;
    localparam logic [3:0] SYNC_OK    = 4'b0000;
    localparam logic [3:0] PARK_ONES  = 4'b1111;

endpackage

// File: rtl/fwh_frame_seq.sv
module fwh_frame_seq
    import fwh_pkg::*;
#(
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 28,
    parameter int DATA_W  = 8,
    parameter int NIB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output phase_e            phase,
    output logic [$clog2(ADDR_W/NIB_W)-1:0] idx,
    output logic [ID_W-1:0]   lat_id,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              take
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;
    localparam int IDX_W     = $clog2(ADDR_NIBS);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_NIBS - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_NIBS - 1);

    typedef struct packed {
        phase_e            ph;
        logic [IDX_W-1:0]  idx;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    take    = 1'b1;
                    st_d.ph = PH_START;
                    st_d.id = req_id;
                    st_d.addr = req_addr;
                    st_d.data = req_data;
                    st_d.idx = '0;
                end
            end
            PH_START: st_d.ph = PH_SEL;
            PH_SEL: begin
                st_d.ph  = PH_ADDR;
                st_d.idx = '0;
            end
            PH_ADDR: begin
                if (st_q.idx == ADDR_LAST) begin
                    st_d.ph  = PH_SIZE;
                    st_d.idx = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_SIZE: begin
                st_d.ph  = PH_DATA;
                st_d.idx = '0;
            end
            PH_DATA: begin
                if (st_q.idx == DATA_LAST) begin
                    st_d.ph  = PH_HOFF;
                    st_d.idx = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_HOFF:  st_d.ph = PH_FLOAT;
            PH_FLOAT: st_d.ph = PH_SYNC;
            PH_SYNC:  st_d.ph = PH_TOFF;
            PH_TOFF:  st_d.ph = PH_BACK;
            PH_BACK:  st_d.ph = PH_IDLE;
            default:  st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, idx: '0, id: '0, addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.ph;
    assign idx      = st_q.idx;
    assign lat_id   = st_q.id;
    assign lat_addr = st_q.addr;
    assign lat_data = st_q.data;

endmodule

// File: rtl/fwh_nibble_mux.sv
module fwh_nibble_mux
    import fwh_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  phase_e            phase,
    input  logic [$clog2(ADDR_W/NIB_W)-1:0] idx,
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [NIB_W-1:0]  nib,
    output logic              oe,
    output logic              strobe_n
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int DATA_NIBS = DATA_W / NIB_W;

    logic [NIB_W-1:0] addr_nib [ADDR_NIBS];
    logic [NIB_W-1:0] data_nib [DATA_NIBS];

    // Address leaves most significant nibble first
    for (genvar a = 0; a < ADDR_NIBS; a++) begin : g_addr
        assign addr_nib[a] = addr[(ADDR_NIBS-1-a)*NIB_W +: NIB_W];
    end

    // Data leaves least significant nibble first
    for (genvar b = 0; b < DATA_NIBS; b++) begin : g_data
        assign data_nib[b] = data[b*NIB_W +: NIB_W];
    end

    always_comb begin
        nib      = PARK_ONES;
        oe       = 1'b1;
        strobe_n = 1'b1;
        unique case (phase)
            PH_START: begin
                nib      = START_CODE;
                strobe_n = 1'b0;
            end
            PH_SEL:   nib = NIB_W'(id);
            PH_ADDR:  nib = addr_nib[idx];
            PH_SIZE:  nib = SIZE_ONE;
            PH_DATA:  nib = data_nib[idx[$clog2(DATA_NIBS)-1:0]];
            PH_HOFF:  nib = PARK_ONES;
            PH_FLOAT,
            PH_SYNC,
            PH_TOFF:  oe  = 1'b0;
            default:  nib = PARK_ONES;
        endcase
    end

endmodule

// File: rtl/fwh_sync_eval.sv
module fwh_sync_eval
    import fwh_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic [NIB_W-1:0] bus_in,
    output logic             bad
);

    logic bad_d, bad_q;

    always_comb begin
        bad_d = bad_q;
        if (clear) begin
            bad_d = 1'b0;
        end else if (sample) begin
            bad_d = (bus_in != NIB_W'(SYNC_OK));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else begin
            bad_q <= bad_d;
        end
    end

    assign bad = bad_q;

endmodule

// File: rtl/fwh_wr_init.sv
module fwh_wr_init
    import fwh_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 28,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe,
    input  logic [NIB_W-1:0]  bus_in,
    output logic              frame_n,
    output logic              done,
    output logic              err
);

    localparam int IDX_W = $clog2(ADDR_W / NIB_W);

    phase_e            phase;
    logic [IDX_W-1:0]  idx;
    logic [ID_W-1:0]   lat_id;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              take;
    logic              bad;

    fwh_frame_seq #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_id(req_id),
        .req_addr(req_addr), .req_data(req_data),
        .phase(phase), .idx(idx),
        .lat_id(lat_id), .lat_addr(lat_addr), .lat_data(lat_data),
        .take(take)
    );

    fwh_nibble_mux #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)
    ) u_mux (
        .phase(phase), .idx(idx),
        .id(lat_id), .addr(lat_addr), .data(lat_data),
        .nib(bus_out), .oe(bus_oe), .strobe_n(frame_n)
    );

    fwh_sync_eval #(
        .NIB_W(NIB_W)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .clear(take),
        .sample(phase == PH_SYNC),
        .bus_in(bus_in),
        .bad(bad)
    );

    assign req_ready = (phase == PH_IDLE);
    assign done      = (phase == PH_BACK);
    assign err       = done & bad;

endmodule

// File: rtl/fwh_wr_init_chk.sv
module fwh_wr_init_chk #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [NIB_W-1:0] bus_out,
    input logic             bus_oe,
    input logic             frame_n,
    input logic             done,
    input logic             err
);

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !frame_n);

    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $past(req_valid && req_ready));

    // R3
    strobe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> (bus_oe && bus_out == 4'b1110));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> frame_n);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R11
    done_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_oe && bus_out == 4'b1111));

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8
    released_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !req_ready);

endmodule

bind fwh_wr_init fwh_wr_init_chk #(.NIB_W(NIB_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bus_out(bus_out), .bus_oe(bus_oe), .frame_n(frame_n),
    .done(done), .err(err)
);

// File: tb/sim_fwh_wr_init.sv
module sim_fwh_wr_init;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_id = '0;
    logic [27:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic [3:0]  bus_in = 4'hF;
    logic        frame_n;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit       oe;
        bit [3:0] val;
        bit       fr_n;
        bit       dn;
        bit       er;
        string    tag;
    } exp_t;

    exp_t     exp_q[$];
    bit [3:0] sync_q[$];

    always #2 clk = ~clk;   // 250 MHz

    fwh_wr_init u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_addr(req_addr), .req_data(req_data),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .frame_n(frame_n), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic exp_t mk(bit oe, bit [3:0] v, bit fr_n, bit dn, bit er, string tag);
        exp_t e;
        e.oe = oe; e.val = v; e.fr_n = fr_n; e.dn = dn; e.er = er; e.tag = tag;
        return e;
    endfunction

    // Called at a falling edge; returns at a falling edge after acceptance
    task automatic send(input bit [3:0] id, input bit [27:0] a, input bit [7:0] d,
                        input bit [3:0] sync);
        bit er;
        req_valid = 1'b1;
        req_id = id; req_addr = a; req_data = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        er = (sync != 4'b0000);
        sync_q.push_back(sync);
        exp_q.push_back(mk(1, 4'b1110, 0, 0, 0, "R3"));
        exp_q.push_back(mk(1, id, 1, 0, 0, "R4"));
        for (int k = 6; k >= 0; k--)
            exp_q.push_back(mk(1, a[k*4 +: 4], 1, 0, 0, "R5"));
        exp_q.push_back(mk(1, 4'b0000, 1, 0, 0, "R6"));
        exp_q.push_back(mk(1, d[3:0], 1, 0, 0, "R7"));
        exp_q.push_back(mk(1, d[7:4], 1, 0, 0, "R7"));
        exp_q.push_back(mk(1, 4'b1111, 1, 0, 0, "R8"));
        exp_q.push_back(mk(0, 4'b0000, 1, 0, 0, "R8"));
        exp_q.push_back(mk(0, 4'b0000, 1, 0, 0, "R8"));
        exp_q.push_back(mk(0, 4'b0000, 1, 0, 0, "R8"));
        exp_q.push_back(mk(1, 4'b1111, 1, 1, er, er ? "R10" : "R9"));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and target model
    int cyc = 0;
    bit [3:0] cur_sync = 4'hF;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cyc != 0) cyc++;
            if (cyc > 17) cyc = 0;
            if (cyc == 0 && !frame_n) begin
                cyc = 1;
                cur_sync = (sync_q.size() > 0) ? sync_q.pop_front() : 4'hF;
            end
            bus_in = (cyc == 15) ? cur_sync : 4'hF;
            if (cyc != 0) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(0, "R2", "frame cycle with no request pending");
                end else begin
                    e = exp_q.pop_front();
                    check(bus_oe == e.oe && (!e.oe || bus_out == e.val) &&
                          frame_n == e.fr_n && done == e.dn && err == e.er &&
                          req_ready == 1'b0,
                          e.tag,
                          $sformatf("cyc %0d got oe=%b val=%h fr_n=%b done=%b err=%b rdy=%b exp oe=%b val=%h fr_n=%b done=%b err=%b rdy=0",
                                    cyc, bus_oe, bus_out, frame_n, done, err, req_ready,
                                    e.oe, e.val, e.fr_n, e.dn, e.er));
                end
            end else begin
                // R1 idle state / R11 idle after completion
                check(req_ready && frame_n && bus_oe && bus_out == 4'hF && !done && !err,
                      "R1", $sformatf("idle got rdy=%b fr_n=%b oe=%b val=%h done=%b err=%b exp 1 1 1 f 0 0",
                                      req_ready, frame_n, bus_oe, bus_out, done, err));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready && frame_n && bus_oe && bus_out == 4'hF && !done && !err,
              "R1", $sformatf("reset got rdy=%b fr_n=%b oe=%b val=%h done=%b err=%b",
                              req_ready, frame_n, bus_oe, bus_out, done, err));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        send(4'h3, 28'h1234567, 8'hA5, 4'b0000);    // R9 good sync
        repeat (5) @(negedge clk);
        send(4'hC, 28'hFFFFFFF, 8'h0F, 4'b0101);    // R10 bad sync
        // R2: next request held valid during the frame, back to back
        send(4'h0, 28'h0000000, 8'hF0, 4'b0000);
        send(4'hF, 28'h8C3E1D9, 8'h7E, 4'b1111);    // R10 all-ones sync
        send(4'h9, 28'h0F0F0F0, 8'h81, 4'b0000);    // R11 back to idle
        while (exp_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R2: watchdog expired, got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule